// File: doc/BRIEF.md
# PWM Input Period and High-Time Meter

This block measures an external pulse-width-modulated signal in counter ticks. The input pin passes through a two-flop synchronizer and then an edge detector. The counter is free-running, cleared when a measurement starts, and advances once every `psc + 1` clock cycles. It wraps to zero after reaching `CNT_MAX - 1`. Two capture units watch the same pin. Capture unit A records the counter on rising edges and capture unit B records it on falling edges.

A measurement is started with a one-cycle `start` pulse. The first qualifying rising edge sets the reference time. The second one completes the measurement: the counter value at that moment, together with the value held by unit B, forms the closing snapshot pair. From these values the block computes the period and the high time. It corrects for counter wrap, for a falling-edge capture that overwrote unit B late, and for a start that falls in the high phase when the edge divider is above 1.

An edge divider makes both capture units latch only on every first, second, fourth or eighth qualifying edge. A programmable limit on clock cycles ends a measurement that never completes.

Top module: `pwmcap_top`

## Requirements
- R1: After reset, `busy`, `done` and `timeout` are 0, and `period_o` and `high_o` are 0.
- R2: One cycle after `start` is sampled high, `busy` is 1 and `done` and `timeout` are 0. `start` also clears the counter, the clock divider, both edge-divider counters and both capture registers. `psc`, `edge_div_sel` and `tmo_limit` are taken in at `start`.
- R3: With `edge_div_sel = 0`, `period_o` is the number of ticks between two consecutive rising edges of `pwm_in`.
- R4: `high_o` is the number of ticks from a rising edge to the following falling edge. Rising and falling edges never produce a capture in the same cycle.
- R5: The counter runs from 0 to `CNT_MAX - 1` and then returns to 0. A later capture value below the reference value `t0` gives a difference of `CNT_MAX - t0 + later`. This makes results correct across a wrap.
- R6: `edge_div_sel` encodes the edge divider N as 0 = 1, 1 = 2, 2 = 4 and 3 = 8. Each capture unit latches on the first qualifying edge after `start` and then on every Nth one. `period_o` is the span covering N periods shifted right by log2 N.
- R7: The high time is corrected in two steps. First, if the raw high time exceeds the span, the span is subtracted from it. Second, if N > 1 and the result is at least span>>k (where k = log2 N), it becomes (span>>k) - (span - high). With these corrections, a start in the high phase still reports the true high time.
- R8: `done` rises exactly one cycle after the closing rising-edge capture. `busy` falls at the same time. While `done` is held, `period_o` and `high_o` stay constant until the next `start`.
- R9: If no closing capture occurs within `tmo_limit` busy cycles, `timeout` becomes 1, and `busy` and `done` are 0. `done` and `timeout` are never high together.
- R10: A tick lasts `psc + 1` clock cycles, so results are expressed in divided ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | Asynchronous PWM input |
| start | input | 1 | One-cycle pulse that begins a measurement |
| psc | input | PSC_W | Tick divider; a tick is psc+1 clocks |
| edge_div_sel | input | 2 | Edge divider select: 0 = 1, 1 = 2, 2 = 4, 3 = 8 |
| tmo_limit | input | TMO_W | Timeout limit in clock cycles |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Results valid |
| timeout | output | 1 | Measurement abandoned |
| period_o | output | CNT_W | Period in ticks |
| high_o | output | CNT_W | High time in ticks |

## Verification
The assertions check the following on every cycle:
- the counter never leaves its range;
- rising and falling captures never coincide;
- `start` always arms the block;
- `done` rises only one cycle after a closing capture and excludes both `busy` and `timeout`;
- the results hold while `done` is high.

The numeric results need the bench's scenarios. These include random periods, duties, tick dividers and edge dividers, compared against bench arithmetic. Directed cases force a counter wrap, a start in the high phase with N = 4, and a timeout followed by a clean restart.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } meas_state_e;
endpackage

// File: rtl/pwmcap_sync_edge.sv
module pwmcap_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/pwmcap_timebase.sv
module pwmcap_timebase #(
  parameter int CNT_W   = 16,
  parameter int CNT_MAX = 2 ** CNT_W,
  parameter int PSC_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_MAX - 1);

  logic [PSC_W-1:0] div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0;
      cnt <= '0;
    end else if (clr) begin
      div <= '0;
      cnt <= '0;
    end else if (run) begin
      if (div == psc) begin
        div <= '0;
        cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
      end else begin
        div <= div + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwmcap_edge_gate.sv
module pwmcap_edge_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       edge_in,
  input  logic [1:0] sel,
  output logic       latch
);
  logic [2:0] ecnt;
  logic [2:0] mask;

  always_comb begin
    case (sel)
      2'd0:    mask = 3'd0;
      2'd1:    mask = 3'd1;
      2'd2:    mask = 3'd3;
      default: mask = 3'd7;
    endcase
  end

  assign latch = en && edge_in && (ecnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ecnt <= 3'd0;
    else if (clr)            ecnt <= 3'd0;
    else if (en && edge_in)  ecnt <= (ecnt + 3'd1) & mask;
  end
endmodule

// File: rtl/pwmcap_top.sv
module pwmcap_top #(
  parameter int CNT_W   = 16,
  parameter int CNT_MAX = 2 ** CNT_W,
  parameter int PSC_W   = 16,
  parameter int TMO_W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             start,
  input  logic [PSC_W-1:0] psc,
  input  logic [1:0]       edge_div_sel,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] high_o
);
  import pwmcap_pkg::*;

  localparam logic [CNT_W-1:0] CMAX_W = CNT_W'(CNT_MAX);

  // Difference with wrap: modular arithmetic in CNT_W bits is exact because
  // every true difference is below CNT_MAX (R5).
  function automatic logic [CNT_W-1:0] wrap_diff(input logic [CNT_W-1:0] ref_v,
                                                 input logic [CNT_W-1:0] later);
    if (later >= ref_v) return later - ref_v;
    return CMAX_W - ref_v + later;
  endfunction

  // High-time corrections: late overwrite, then divided-edge start phase (R7).
  function automatic logic [CNT_W-1:0] fix_high(input logic [CNT_W-1:0] span,
                                                input logic [CNT_W-1:0] raw,
                                                input logic [1:0]       k);
    logic [CNT_W-1:0] h;
    logic [CNT_W-1:0] per;
    h = raw;
    if (h > span) h = h - span;
    per = span >> k;
    if ((k != 2'd0) && (h >= per)) h = per - (span - h);
    return h;
  endfunction

  meas_state_e      state;
  logic [PSC_W-1:0] psc_q;
  logic [1:0]       sel_q;
  logic [TMO_W-1:0] tmo_q;
  logic [TMO_W-1:0] elapsed;
  logic [CNT_W-1:0] tick_cnt;
  logic [CNT_W-1:0] cap_a;
  logic [CNT_W-1:0] cap_b;
  logic             rise_evt, fall_evt;
  logic [1:0]       latch_vec;
  logic             cap_a_evt, cap_b_evt;
  logic             first_evt, fin_evt, tmo_evt;
  logic [CNT_W-1:0] span_c, raw_high_c;

  pwmcap_sync_edge u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pwm_in),
    .rise (rise_evt),
    .fall (fall_evt)
  );

  pwmcap_timebase #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX), .PSC_W(PSC_W)) u_tb (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start),
    .run  (busy),
    .psc  (psc_q),
    .cnt  (tick_cnt)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_gate
    logic edge_src;
    assign edge_src = (gi == 0) ? rise_evt : fall_evt;
    pwmcap_edge_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start),
      .en     (busy),
      .edge_in(edge_src),
      .sel    (sel_q),
      .latch  (latch_vec[gi])
    );
  end

  assign busy       = (state != ST_IDLE);
  assign cap_a_evt  = latch_vec[0];
  assign cap_b_evt  = latch_vec[1];
  assign first_evt  = cap_a_evt && (state == ST_FIRST);
  assign fin_evt    = cap_a_evt && (state == ST_SECOND);
  assign tmo_evt    = busy && !fin_evt && (elapsed == tmo_q);

  // Closing pair: cap_a still holds t0, tick_cnt is t2, cap_b is t1.
  assign span_c     = wrap_diff(cap_a, tick_cnt);
  assign raw_high_c = wrap_diff(cap_a, cap_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
    end else if (start) begin
      cap_a <= '0;
      cap_b <= '0;
    end else begin
      if (cap_a_evt) cap_a <= tick_cnt;
      if (cap_b_evt) cap_b <= tick_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      psc_q    <= '0;
      sel_q    <= 2'd0;
      tmo_q    <= '0;
      elapsed  <= '0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      period_o <= '0;
      high_o   <= '0;
    end else if (start) begin
      state    <= ST_FIRST;
      psc_q    <= psc;
      sel_q    <= edge_div_sel;
      tmo_q    <= tmo_limit;
      elapsed  <= '0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      period_o <= '0;
      high_o   <= '0;
    end else if (busy) begin
      elapsed <= elapsed + 1'b1;
      if (fin_evt) begin
        state    <= ST_IDLE;
        done     <= 1'b1;
        period_o <= span_c >> sel_q;
        high_o   <= fix_high(span_c, raw_high_c, sel_q);
      end else if (tmo_evt) begin
        state   <= ST_IDLE;
        timeout <= 1'b1;
      end else if (first_evt) begin
        state <= ST_SECOND;
      end
    end
  end
endmodule

// File: rtl/pwmcap_checker.sv
module pwmcap_checker #(
  parameter int CNT_W   = 16,
  parameter int CNT_MAX = 2 ** CNT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             timeout,
  input logic             fin_evt,
  input logic             cap_a_evt,
  input logic             cap_b_evt,
  input logic [CNT_W-1:0] tick_cnt,
  input logic [CNT_W-1:0] period_o,
  input logic [CNT_W-1:0] high_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_MAX - 1);

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && !timeout)); // R2
  AST_EDGE_KINDS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_a_evt && cap_b_evt)); // R4
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt <= CNT_LAST); // R5
  AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fin_evt)); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(period_o) && $stable(high_o))); // R8
  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout)); // R9
  AST_TIMEOUT_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(busy)); // R9
endmodule

bind pwmcap_top pwmcap_checker #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .timeout  (timeout),
  .fin_evt  (fin_evt),
  .cap_a_evt(cap_a_evt),
  .cap_b_evt(cap_b_evt),
  .tick_cnt (tick_cnt),
  .period_o (period_o),
  .high_o   (high_o)
);

// File: tb/pwmcap_top_bench.sv
module pwmcap_top_bench;
  localparam int CW  = 16;
  localparam int CMX = 200;
  localparam int PW  = 8;
  localparam int TW  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwm_in = 1'b0;
  logic          start = 1'b0;
  logic [PW-1:0] psc = '0;
  logic [1:0]    edge_div_sel = 2'd0;
  logic [TW-1:0] tmo_limit = TW'(20000);
  logic          busy, done, timeout;
  logic [CW-1:0] period_o, high_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit gen_en = 1'b0;
  int gen_hi = 4, gen_lo = 4, gen_scale = 1;

  always #2 clk = ~clk;

  pwmcap_top #(.CNT_W(CW), .CNT_MAX(CMX), .PSC_W(PW), .TMO_W(TW)) u_pwmcap_top (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .start(start), .psc(psc),
    .edge_div_sel(edge_div_sel), .tmo_limit(tmo_limit), .busy(busy),
    .done(done), .timeout(timeout), .period_o(period_o), .high_o(high_o)
  );

  function automatic int exp_period(input int hi, input int lo);
    return hi + lo;
  endfunction

  function automatic int exp_high(input int hi);
    return hi;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // PWM source: phase lengths in ticks times the tick divider
  initial begin
    forever begin
      if (gen_en) begin
        pwm_in = 1'b1;
        repeat (gen_hi * gen_scale) @(negedge clk);
        pwm_in = 1'b0;
        repeat (gen_lo * gen_scale) @(negedge clk);
      end else begin
        pwm_in = 1'b0;
        @(negedge clk);
      end
    end
  end

  task automatic configure(input int hi, input int lo, input int p, input int sel);
    gen_hi = hi; gen_lo = lo; gen_scale = p + 1; gen_en = 1'b1;
    psc = PW'(p); edge_div_sel = 2'(sel);
    repeat (2 * (hi + lo) * (p + 1) + 20) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!done && !timeout && n < 40000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(input string req, input int hi, input int lo);
    wait_end();
    check({req, " done"}, int'(done), 1);
    check({req, " period"}, int'(period_o), exp_period(hi, lo));
    check({"R4 high ", req}, int'(high_o), exp_high(hi));
  endtask

  initial begin
    int seed_v;
    int hi, lo, p, sel;
    seed_v = $urandom(1234);
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 timeout", int'(timeout), 0);
    check("R1 period", int'(period_o), 0);
    check("R1 high", int'(high_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 basic, no dividers
    configure(6, 10, 0, 0);
    pulse_start();
    check("R2 busy after start", int'(busy), 1);
    measure("R3", 6, 10);
    check("R8 busy low at done", int'(busy), 0);
    repeat (30) @(negedge clk);
    check("R8 period held", int'(period_o), 16);
    check("R8 high held", int'(high_o), 6);

    // R5 wrap: start just after a rising edge so t2 passes CMX
    configure(90, 99, 0, 0);
    @(posedge pwm_in);
    repeat (5) @(negedge clk);
    pulse_start();
    measure("R5", 90, 99);

    // R7 start inside the high phase with N=4
    configure(10, 15, 1, 2);
    @(posedge pwm_in);
    repeat (3) @(negedge clk);
    pulse_start();
    measure("R7", 10, 15);

    // R6 start inside the low phase with N=8
    configure(5, 7, 0, 3);
    @(negedge pwm_in);
    repeat (2) @(negedge clk);
    pulse_start();
    measure("R6", 5, 7);

    // R10 tick divider of 4 with N=2
    configure(7, 9, 3, 1);
    repeat (11) @(negedge clk);
    pulse_start();
    measure("R10", 7, 9);

    // R9 timeout with a silent input
    gen_en = 1'b0;
    repeat (10) @(negedge clk);
    tmo_limit = TW'(300);
    pulse_start();
    repeat (290) @(negedge clk);
    check("R9 busy before limit", int'(busy), 1);
    check("R9 no timeout before limit", int'(timeout), 0);
    repeat (20) @(negedge clk);
    check("R9 timeout", int'(timeout), 1);
    check("R9 busy cleared", int'(busy), 0);
    check("R9 done low", int'(done), 0);
    tmo_limit = TW'(20000);
    pulse_start();
    check("R2 timeout cleared", int'(timeout), 0);
    check("R2 busy", int'(busy), 1);
    configure(3, 4, 0, 0);
    wait_end();
    pulse_start();
    measure("R2 restart", 3, 4);

    // random trials: N*(hi+lo) stays below CMX
    for (int t = 0; t < 16; t++) begin
      hi  = $urandom_range(2, 12);
      lo  = $urandom_range(2, 12);
      p   = $urandom_range(0, 3);
      sel = $urandom_range(0, 3);
      configure(hi, lo, p, sel);
      repeat ($urandom_range(0, 40)) @(negedge clk);
      pulse_start();
      measure((sel == 0) ? "R3" : "R6", hi, lo);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule